// File: doc/BRIEF.md
# Video Interrupt and Line-Sync Controller

This block is the non-maskable interrupt logic of a video display controller, plus the stall that lets the CPU wait for the end of a scan line. Three event sources feed it: a display-list interrupt (an interrupt-flagged mode line reaching its last scan line), the end of the frame's vertical-blank jump instruction, and an asynchronous reset key. Every event is recorded in a sticky status register. Only events whose enable bit is set drive a fixed-length low pulse on the active-low `nmi_n` output.

Software reaches the block over a small synchronous register bus. There is a write-only enable register and a status register. A write of any value to the status address clears the status. A write to the sync address drops `cpu_rdy` until the next horizontal-sync rising edge. A line-count register returns the current scan line halved, so the value fits in one byte.

Top module: `vnmi_ctrl`

## Requirements
- R1: A write to EN_ADDR (default 0xE) stores the enable bits: bit 7 enables the display-list event, bit 6 the vertical-blank event and bit 5 the reset-key event. Bits 4..0 are ignored. A read of EN_ADDR returns 0x00.
- R2: A read of STAT_ADDR (default 0xF) returns the status: bit 7 for the display-list event, bit 6 for vertical blank, bit 5 for the reset key, and bits 4..0 as 0. A status bit is set by its event whatever the enable setting, and it stays set until cleared.
- R3: A write of any value to STAT_ADDR clears all status bits. An event arriving in the same cycle as the clear leaves its bit set.
- R4: A display-list event occurs only in a cycle where `dli_flag` and `last_line` are both high. Either input alone has no effect.
- R5: A high `vbl_done` in a cycle is a vertical-blank event.
- R6: `rst_key` is asynchronous. It passes through two synchronizing flops, and only its rising edge is an event. Holding it high gives one event, recorded at the third clock edge after the input rises.
- R7: An enabled event drives `nmi_n` low from the next clock edge for PULSE_LEN cycles (default 4). A disabled event gives no pulse. A new enabled event during a pulse restarts the full length.
- R8: A write of any value to SYNC_ADDR (default 0xA) drives `cpu_rdy` low from the next edge. It stays low until the edge at which an `hsync` rising edge is seen, and then returns high at that edge. A write in the same cycle as an `hsync` rising edge leaves `cpu_rdy` high.
- R9: The line counter counts `hsync` rising edges. `frame_start` clears it, and it saturates at MAX_LINES-1 (default 312). A read of LINE_ADDR (default 0xB) returns the count divided by two (155 at most by default).
- R10: After reset, `nmi_n` and `cpu_rdy` are high, and status, enable, line count and `bus_rdata` are zero. `bus_rdata` is registered and is updated only on a read. Unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| dli_flag | input | 1 | Current mode instruction carries the interrupt modifier |
| last_line | input | 1 | Last scan line of the current mode line |
| vbl_done | input | 1 | Vertical-blank jump instruction finished |
| rst_key | input | 1 | Asynchronous reset-key level |
| hsync | input | 1 | Horizontal sync level, synchronous to clk |
| frame_start | input | 1 | Clears the line counter |
| nmi_n | output | 1 | Active-low interrupt pulse |
| cpu_rdy | output | 1 | CPU ready; low while stalled |

## Verification
A corrupted status bit shows in the next status read. A wrong enable or a wrong pulse counter shows at `nmi_n` on the edge after an event, or PULSE_LEN cycles after it. A stuck stall flag shows on `cpu_rdy` at the edge after a sync write or after the `hsync` edge that should release it. Errors in the reset-key synchronizer show up as a pulse two cycles too early or too late, or as repeated events while the key is held.

// File: rtl/vnmi_pkg.sv
package vnmi_pkg;
  localparam int SRC_N   = 3;
  localparam int IDX_DLI = 2;
  localparam int IDX_VBL = 1;
  localparam int IDX_KEY = 0;
endpackage

// File: rtl/vnmi_edge.sv
module vnmi_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic lvl;
  logic prev;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = din;
    end else begin : g_sync
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= (sr << 1) | STAGES'(din);
      end
      assign lvl = sr[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/vnmi_pulse.sv
module vnmi_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic nmi_n
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      nmi_n <= 1'b1;
    end else if (fire) begin
      cnt   <= CW'(PULSE_LEN);
      nmi_n <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      nmi_n <= !(cnt > CW'(1));
    end
  end
endmodule

// File: rtl/vnmi_line_cnt.sv
module vnmi_line_cnt #(
  parameter int MAX_LINES = 312,
  localparam int LINE_W   = $clog2(MAX_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              hs_edge,
  output logic [LINE_W-1:0] line
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(MAX_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst || frame_start)            line <= '0;
    else if (hs_edge && line != LAST)  line <= line + 1'b1;
  end
endmodule

// File: rtl/vnmi_ctrl.sv
module vnmi_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 4,
  parameter int MAX_LINES = 312,
  parameter int KEY_SYNC  = 2,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 4'hE,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'hF,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 4'hA,
  parameter logic [ADDR_W-1:0] LINE_ADDR = 4'hB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dli_flag,
  input  logic              last_line,
  input  logic              vbl_done,
  input  logic              rst_key,
  input  logic              hsync,
  input  logic              frame_start,
  output logic              nmi_n,
  output logic              cpu_rdy
);
  import vnmi_pkg::*;
  localparam int LINE_W = $clog2(MAX_LINES);

  logic wr, rd, wr_en, wr_clr, wr_sync;
  logic key_edge, hs_edge, fire;
  logic [SRC_N-1:0] evt, en, stat;
  logic [LINE_W-1:0] line;
  logic [DATA_W-1:0] rd_mux;

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign wr_en   = wr && (bus_addr == EN_ADDR);
  assign wr_clr  = wr && (bus_addr == STAT_ADDR);
  assign wr_sync = wr && (bus_addr == SYNC_ADDR);

  vnmi_edge #(.STAGES(KEY_SYNC)) u_key (
    .clk(clk), .rst(rst), .din(rst_key), .rise(key_edge));

  vnmi_edge #(.STAGES(0)) u_hs (
    .clk(clk), .rst(rst), .din(hsync), .rise(hs_edge));

  assign evt[IDX_DLI] = dli_flag & last_line;
  assign evt[IDX_VBL] = vbl_done;
  assign evt[IDX_KEY] = key_edge;
  assign fire         = |(evt & en);

  always_ff @(posedge clk) begin
    if (rst)        en <= '0;
    else if (wr_en) en <= bus_wdata[DATA_W-1 -: SRC_N];
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (wr_clr ? '0 : stat) | evt;
  end

  vnmi_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .nmi_n(nmi_n));

  always_ff @(posedge clk) begin
    if (rst)          cpu_rdy <= 1'b1;
    else if (hs_edge) cpu_rdy <= 1'b1;
    else if (wr_sync) cpu_rdy <= 1'b0;
  end

  vnmi_line_cnt #(.MAX_LINES(MAX_LINES)) u_lines (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .hs_edge(hs_edge), .line(line));

  always_comb begin
    rd_mux = '0;
    if (bus_addr == STAT_ADDR)      rd_mux = {stat, {(DATA_W-SRC_N){1'b0}}};
    else if (bus_addr == LINE_ADDR) rd_mux = DATA_W'(line >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/vnmi_ctrl_chk.sv
module vnmi_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_sync,
  input logic       wr_clr,
  input logic       hs_edge,
  input logic       cpu_rdy,
  input logic       nmi_n,
  input logic       fire,
  input logic [2:0] evt,
  input logic [2:0] stat
);
  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_sync && !hs_edge) |=> !cpu_rdy);
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    hs_edge |=> cpu_rdy);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rdy && !hs_edge) |=> !cpu_rdy);
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && evt == 3'b000) |=> stat == 3'b000);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (stat[2] && !wr_clr) |=> stat[2]);
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    evt[2] |=> stat[2]);
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> !nmi_n);
  assert_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |-> $past(fire));
endmodule

bind vnmi_ctrl vnmi_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_sync(wr_sync), .wr_clr(wr_clr),
  .hs_edge(hs_edge), .cpu_rdy(cpu_rdy), .nmi_n(nmi_n), .fire(fire),
  .evt(evt), .stat(stat));

// File: tb/tb_vnmi_ctrl.sv
module tb_vnmi_ctrl;
  localparam int PULSE = 4;
  localparam int LINES = 312;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic dli_flag = 0, last_line = 0, vbl_done = 0, rst_key = 0;
  logic hsync = 0, frame_start = 0;
  logic nmi_n, cpu_rdy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vnmi_ctrl #(.PULSE_LEN(PULSE), .MAX_LINES(LINES)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dli_flag(dli_flag), .last_line(last_line), .vbl_done(vbl_done),
    .rst_key(rst_key), .hsync(hsync), .frame_start(frame_start),
    .nmi_n(nmi_n), .cpu_rdy(cpu_rdy));

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    tick();
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic expect_pulse(input string req);
    check({req, " pulse start"}, nmi_n, 0);
    for (int i = 1; i < PULSE; i++) begin tick(); check({req, " pulse body"}, nmi_n, 0); end
    tick(); check({req, " pulse end"}, nmi_n, 1);
  endtask

  task automatic hs_pulse();
    hsync = 1; tick(); hsync = 0; tick();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 nmi_n", nmi_n, 1);
    check("R10 cpu_rdy", cpu_rdy, 1);
    check("R10 rdata", bus_rdata, 0);
    rd(4'hF, d); check("R10 status", d, 0);
    rd(4'hE, d); check("R1 enable reads zero", d, 0);
    rd(4'h3, d); check("R10 unmapped", d, 0);
  endtask

  task automatic t_dli();
    logic [7:0] d;
    wr(4'hE, 8'h80);
    dli_flag = 1; tick(); dli_flag = 0;
    check("R4 flag alone", nmi_n, 1);
    last_line = 1; tick(); last_line = 0;
    check("R4 last line alone", nmi_n, 1);
    rd(4'hF, d); check("R4 no status", d, 0);
    dli_flag = 1; last_line = 1; tick(); dli_flag = 0; last_line = 0;
    expect_pulse("R7 dli");
    rd(4'hF, d); check("R2 dli status", d, 8'h80);
    wr(4'hF, 8'h00);
    rd(4'hF, d); check("R3 cleared", d, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(4'hE, 8'h1F);
    vbl_done = 1; tick(); vbl_done = 0;
    check("R1 low bits ignored", nmi_n, 1);
    tick(); check("R1 low bits ignored later", nmi_n, 1);
    rd(4'hF, d); check("R2 status without enable", d, 8'h40);
    wr(4'hF, 8'h5A);
    wr(4'hE, 8'h40);
    vbl_done = 1; tick(); vbl_done = 0;
    expect_pulse("R5 vbl");
    vbl_done = 1; tick(); vbl_done = 0;
    tick(); tick();
    vbl_done = 1; tick(); vbl_done = 0;
    expect_pulse("R7 retrigger");
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr(4'hF, 8'hFF);
    vbl_done = 1;
    wr(4'hF, 8'h00);
    vbl_done = 0;
    rd(4'hF, d); check("R3 event wins over clear", d, 8'h40);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h00);
    tick(); tick(); tick(); tick(); tick();
  endtask

  task automatic t_key();
    logic [7:0] d;
    wr(4'hE, 8'h20);
    rst_key = 1;
    tick(); check("R6 edge1", nmi_n, 1);
    tick(); check("R6 edge2", nmi_n, 1);
    tick();
    expect_pulse("R6 key");
    for (int i = 0; i < 10; i++) tick();
    check("R6 held no repeat", nmi_n, 1);
    rd(4'hF, d); check("R6 key status", d, 8'h20);
    wr(4'hF, 8'h00);
    tick(); tick();
    rd(4'hF, d); check("R6 held no new event", d, 0);
    rst_key = 0; tick(); tick(); tick();
    wr(4'hE, 8'h00);
  endtask

  task automatic t_sync();
    hsync = 0;
    wr(4'hA, 8'h00);
    check("R8 stall", cpu_rdy, 0);
    tick(); tick(); tick();
    check("R8 still stalled", cpu_rdy, 0);
    hsync = 1; tick();
    check("R8 released on edge", cpu_rdy, 1);
    hsync = 0; tick();
    hsync = 1;
    wr(4'hA, 8'h11);
    check("R8 write with edge", cpu_rdy, 1);
    wr(4'hA, 8'h22);
    check("R8 level is not an edge", cpu_rdy, 0);
    hsync = 0; tick();
    check("R8 falling no release", cpu_rdy, 0);
    hsync = 1; tick(); hsync = 0;
    check("R8 second release", cpu_rdy, 1);
  endtask

  task automatic t_lines();
    logic [7:0] d;
    frame_start = 1; tick(); frame_start = 0;
    rd(4'hB, d); check("R9 cleared", d, 0);
    for (int i = 0; i < 7; i++) hs_pulse();
    rd(4'hB, d); check("R9 seven lines", d, 3);
    hs_pulse(); hs_pulse();
    rd(4'hB, d); check("R9 nine lines", d, 4);
    for (int i = 0; i < 400; i++) hs_pulse();
    rd(4'hB, d); check("R9 saturate", d, (LINES - 1) / 2);
    frame_start = 1; tick(); frame_start = 0;
    rd(4'hB, d); check("R9 frame start", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst = 0;
    tick();
    t_reset();
    t_dli();
    t_mask();
    t_collide();
    t_key();
    t_sync();
    t_lines();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule